// File: doc/BRIEF.md
# Token-Passing Gate Controller

This block is a tiny control state machine that either owns or does not own a single token circulating among several copies of itself. While it owns the token it behaves as an open gate: the one-bit data input `x` is copied to the output `q`. When it does not own the token, `q` is held at 0. A pulse on `go` hands the token to the block. A pulse on `hand_off` gives it up. When the block gives the token up, `finish` pulses for one cycle.

Several copies can be joined in a ring. Each `finish` feeds the next copy's `go` through a one-cycle register, so the ring has no combinational loop. One copy receives an initial seed pulse on `go`.

The elaboration parameter `MOORE` selects how `q` is timed:
- With `MOORE = 0` (Mealy, the default), `q` is a combinational function of the held state and `x`.
- With `MOORE = 1` (Moore), `q` comes only from a register. The idle state is split into a q=0 idle state and a q=1 idle state, and reset selects the q=0 one.

Top module: `tokgate_fsm`

## Requirements
- R1: A synchronous active-high `rst` puts the block in the idle (no-token) state with `q` = 0 and `finish` = 0 in the first cycle after the reset edge.
- R2: While idle with `go` low, the block stays idle. `q` stays 0, and in Mealy mode `q` ignores `x`.
- R3: While idle with `go` high, the block holds the token from the next clock. `q` is 0 during the cycle in which `go` is sampled.
- R4: While the block holds the token and `hand_off` is low, it keeps the token. In Mealy mode `q` equals `x` in that same cycle.
- R5: While the block holds the token and `hand_off` is high, it is idle from the next clock. In Mealy mode `q` still equals `x` in the hand-off cycle, so the last data bit gets through.
- R6: `finish` is 1 for exactly the one cycle that follows a hand-off, which is the first cycle back in idle. It is 0 in every other cycle.
- R7: `hand_off` sampled while idle is ignored. It raises no `finish`, and the block stays idle unless `go` is high.
- R8: With `MOORE = 1`, `q` in each cycle equals the Mealy-mode `q` of the previous cycle. This means `x` while holding and 0 while idle, and `q` is 0 right after reset.
- R9: In a ring of two copies with a one-cycle register from each `finish` to the other's `go`, seeded on the first copy, at most one copy holds the token in any cycle. The token returns to the first copy again and again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Hands the token to this block when it is idle |
| x | input | 1 | Data bit gated through while the token is held |
| hand_off | input | 1 | Gives up a held token |
| q | output | 1 | Gated data bit |
| finish | output | 1 | One-cycle pulse after the token is given up |

## Verification
A wrong held/idle state shows up directly on `q` in Mealy mode when `x` is 1. It is visible in the same cycle the state goes wrong. A lost or duplicated hand-off shows on `finish` one cycle after the bad edge. A corrupted data register in Moore mode shows on `q` one cycle after the `x` it should have captured. In the ring, a duplicated token appears as both gates open at once. A lost token appears as the first copy never reopening, within one round of about six cycles.

// File: rtl/tokgate_pkg.sv
package tokgate_pkg;

  // holds: token owned by this stage; qbit: registered output bit (Moore only)
  typedef struct packed {
    logic holds;
    logic qbit;
  } tg_state_t;

  localparam tg_state_t TG_IDLE = '{holds: 1'b0, qbit: 1'b0};

  // Gate function: the data bit passes only while the token is owned.
  function automatic logic tg_gate(input logic holds, input logic x);
    return holds & x;
  endfunction

  // One step of the controller.
  function automatic tg_state_t tg_step(input tg_state_t cur, input logic go,
                                        input logic hand_off, input logic x,
                                        input logic moore);
    tg_state_t n;
    if (!cur.holds) begin
      n.holds = go;
      n.qbit  = 1'b0;
    end else begin
      n.holds = ~hand_off;
      n.qbit  = moore & tg_gate(cur.holds, x);
    end
    return n;
  endfunction

endpackage

// File: rtl/tg_next.sv
module tg_next
  import tokgate_pkg::*;
#(
  parameter bit MOORE = 1'b0
) (
  input  tg_state_t cur,
  input  logic      go,
  input  logic      hand_off,
  input  logic      x,
  output tg_state_t nxt,
  output logic      drop_evt,
  output logic      grab_evt
);

  always_comb begin
    nxt      = tg_step(cur, go, hand_off, x, MOORE);
    drop_evt = cur.holds & hand_off;
    grab_evt = ~cur.holds & go;
  end

endmodule

// File: rtl/tg_state_reg.sv
module tg_state_reg
  import tokgate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  tg_state_t nxt,
  input  logic      drop_evt,
  output tg_state_t cur,
  output logic      finish
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= TG_IDLE;
      finish <= 1'b0;
    end else begin
      cur    <= nxt;
      finish <= drop_evt;
    end
  end

  // R6: a finish pulse is never followed by another
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    finish |=> !finish);

  // R6: finish only appears in idle
  a_r6_finish_idle: assert property (@(posedge clk) disable iff (rst)
    finish |-> !cur.holds);

endmodule

// File: rtl/tokgate_fsm.sv
module tokgate_fsm
  import tokgate_pkg::*;
#(
  parameter bit MOORE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic x,
  input  logic hand_off,
  output logic q,
  output logic finish
);

  tg_state_t st_cur;
  tg_state_t st_nxt;
  logic      drop_evt;
  logic      grab_evt;

  tg_next #(.MOORE(MOORE)) u_next (
    .cur      (st_cur),
    .go       (go),
    .hand_off (hand_off),
    .x        (x),
    .nxt      (st_nxt),
    .drop_evt (drop_evt),
    .grab_evt (grab_evt)
  );

  tg_state_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .nxt      (st_nxt),
    .drop_evt (drop_evt),
    .cur      (st_cur),
    .finish   (finish)
  );

  generate
    if (MOORE) begin : g_moore
      assign q = st_cur.qbit;

      // R8: the registered bit carries last cycle's gated x
      a_r8_moore_delay: assert property (@(posedge clk) disable iff (rst)
        st_cur.holds |=> (q == $past(x)));

      a_r8_moore_idle: assert property (@(posedge clk) disable iff (rst)
        !st_cur.holds |=> !q);
    end else begin : g_mealy
      // qbit never leaves 0 in this style; OR keeps the field in use
      assign q = tg_gate(st_cur.holds, x) | st_cur.qbit;

      // R2: closed gate while idle
      a_r2_idle_closed: assert property (@(posedge clk) disable iff (rst)
        !st_cur.holds |-> !q);
    end
  endgenerate

  // R2: idle without go stays idle
  a_r2_idle_stay: assert property (@(posedge clk) disable iff (rst)
    (!st_cur.holds && !go) |=> !st_cur.holds);

  // R3: go while idle takes the token
  a_r3_grab: assert property (@(posedge clk) disable iff (rst)
    grab_evt |=> st_cur.holds);

  // R4: held without hand-off keeps the token
  a_r4_keep: assert property (@(posedge clk) disable iff (rst)
    (st_cur.holds && !hand_off) |=> st_cur.holds);

  // R5 / R6: hand-off returns to idle with a finish pulse
  a_r5_drop: assert property (@(posedge clk) disable iff (rst)
    drop_evt |=> (!st_cur.holds && finish));

  // R7: hand-off in idle is ignored
  a_r7_ignore: assert property (@(posedge clk) disable iff (rst)
    (!st_cur.holds && hand_off) |=> !finish);

endmodule

// File: tb/tokgate_fsm_tb.sv
`timescale 1ns/1ps
module tokgate_fsm_tb;

  localparam real HALF = 2.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0, x = 1'b0, ho = 1'b0;
  logic q_mealy, fin_mealy, q_moore, fin_moore;

  always #(HALF) clk = ~clk;

  tokgate_fsm #(.MOORE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .go(go), .x(x), .hand_off(ho),
    .q(q_mealy), .finish(fin_mealy));

  tokgate_fsm #(.MOORE(1'b1)) u_moore (
    .clk(clk), .rst(rst), .go(go), .x(x), .hand_off(ho),
    .q(q_moore), .finish(fin_moore));

  // ring of two (R9)
  logic seed = 1'b0, ring_ho = 1'b1;
  logic q0, q1, f0, f1, d0, d1;
  tokgate_fsm #(.MOORE(1'b0)) u_ring0 (
    .clk(clk), .rst(rst), .go(seed | d1), .x(1'b1), .hand_off(ring_ho),
    .q(q0), .finish(f0));
  tokgate_fsm #(.MOORE(1'b0)) u_ring1 (
    .clk(clk), .rst(rst), .go(d0), .x(1'b1), .hand_off(ring_ho),
    .q(q1), .finish(f1));
  always @(posedge clk) begin
    d0 <= rst ? 1'b0 : f0;
    d1 <= rst ? 1'b0 : f1;
  end

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct {
    bit    qa;
    bit    qm;
    bit    fin;
    string tag;
  } exp_t;
  exp_t sb[$];

  // bench reference model
  bit m_hold = 0, m_fin = 0, m_qreg = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: apply inputs for one cycle, push expectation, advance model
  task automatic step(input bit g, input bit h, input bit xv, input string tag);
    exp_t e;
    @(negedge clk);
    go = g; ho = h; x = xv;
    e.qa  = m_hold & xv;
    e.qm  = m_qreg;
    e.fin = m_fin;
    e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    m_fin  = m_hold & h;
    m_qreg = m_hold & xv;
    m_hold = m_hold ? !h : g;
  endtask

  // monitor: compare away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #0.5;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(q_mealy == e.qa, e.tag, "mealy q", q_mealy, e.qa);
        check(fin_mealy == e.fin, e.tag, "finish", fin_mealy, e.fin);
        check(q_moore == e.qm, {e.tag, "/R8"}, "moore q", q_moore, e.qm);
        check(fin_moore == e.fin, {e.tag, "/R8"}, "moore finish", fin_moore, e.fin);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4.0 * 200000);
    check(0, "WDOG", "watchdog", 1, 0);
    finish_run();
  end

  int returns = 0;
  bit ring_on = 0;
  bit q0_prev = 0;

  initial begin
    forever begin
      @(negedge clk);
      #0.7;
      if (ring_on) begin
        check(!(q0 && q1), "R9", "both gates open", 2, 1);
        if (q0 && !q0_prev) returns++;
        q0_prev = q0;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #0.5;
    // R1: reset state
    check(q_mealy == 0, "R1", "mealy q", q_mealy, 0);
    check(fin_mealy == 0, "R1", "finish", fin_mealy, 0);
    check(q_moore == 0, "R1", "moore q", q_moore, 0);
    check(q0 == 0 && q1 == 0, "R1", "ring q", q0 | q1, 0);
    rst = 1'b0;

    step(0, 0, 1, "R2");
    step(0, 0, 1, "R2");
    step(0, 1, 1, "R7");
    step(0, 0, 0, "R7");
    step(1, 0, 1, "R3");
    step(0, 0, 1, "R4");
    step(0, 0, 0, "R4");
    step(0, 0, 1, "R4");
    step(0, 1, 1, "R5");
    step(0, 0, 1, "R6");
    step(0, 1, 0, "R7");
    step(0, 0, 1, "R6");
    step(1, 1, 1, "R3");
    step(0, 1, 0, "R5");
    step(1, 0, 1, "R6");
    step(0, 0, 1, "R4");
    step(0, 1, 1, "R5");
    step(0, 1, 1, "R6");
    step(0, 0, 0, "R2");
    step(0, 0, 0, "R2");
    @(negedge clk);
    #1;

    // R9 ring run
    ring_on = 1;
    @(negedge clk);
    seed = 1'b1;
    @(negedge clk);
    seed = 1'b0;
    repeat (64) @(negedge clk);
    #1;
    ring_on = 0;
    check(returns >= 9, "R9", "token returns to stage 0", returns, 9);
    finish_run();
  end

endmodule